// File: doc/BRIEF.md
# Versioned Configuration Store Controller

This block keeps a configuration image of up to eight bytes in two places: a working copy that the host edits and a backing array that stands in for non-volatile storage. The host reaches the working copy indirectly. It writes a byte offset into one register and then reads or writes the addressed byte through a data window. A third register takes one-hot commands and reports a busy flag. The commands move the image between the two copies (load, save) or wipe the backing array (erase).

Each command walks the image one byte at a time, with a fixed number of clock cycles per byte, so a transfer has a known latency. When a load completes, the block checks the layout version byte. If the version is 0, the flag and bootmode fields are decoded and held on dedicated outputs as power-on defaults for neighbouring blocks. If the version is anything else, the working copy and the defaults fall back to all zero.

Top module: `cfg_store_ctrl`

## Requirements
- R1: After reset, the status reads 0x00 and the offset reads 0. Every working byte is 0x00, every backing byte is 0xFF, busy is low and every default output is 0.
- R2: Register address 0 is command/status, address 1 is the offset and address 2 is the data window. A write to the offset stores bits 2:0, and a read of the offset returns them in bits 2:0 with zeros above. The data window reads and writes the working byte that the offset selects.
- R3: A write to the command register with exactly one of bits 2:0 set starts a command while idle. Bit 0 starts a load, bit 1 a save and bit 2 an erase.
- R4: Busy rises in the cycle after a command is accepted and reads as bit 7 of the status register.
- R5: A command write with more than one of bits 2:0 set is rejected, and busy stays low.
- R6: Busy stays high for exactly IMG_BYTES × CYC_PER_BYTE cycles (64 by default) and then drops.
- R7: Save copies all working bytes into the backing array. Erase sets every backing byte to 0xFF.
- R8: A load whose byte 0 reads 0 copies the backing image into the working copy and updates the defaults. The flags are taken from byte 1 (low) and byte 2 (high), and the bootmode from byte 3 (low) and byte 4 (high). Flag bit 0 drives power-on inhibit, bit 1 bootmode drive, bit 2 watchdog enable, bit 3 failsafe disable and bit 15 debug enable.
- R9: A load whose byte 0 is non-zero leaves every working byte at 0x00 and every default output at 0.
- R10: While busy, writes to the command, offset and data registers are ignored.
- R11: Default outputs change only when a load completes. Data window writes do not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 command/status, 1 offset, 2 data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| busy | output | 1 | Command in progress |
| dflt_pwr_inhibit | output | 1 | Decoded power-on inhibit default |
| dflt_bootmode_drive | output | 1 | Decoded bootmode-drive default |
| dflt_wdog_en | output | 1 | Decoded watchdog-enable default |
| dflt_failsafe_off | output | 1 | Decoded failsafe-disable default |
| dflt_debug_en | output | 1 | Decoded debug-enable default |
| dflt_bootmode | output | 16 | Decoded bootmode default |

## Verification
A running transfer and a host access can fall in the same cycle. The bench provokes this by issuing data, offset and command writes while an erase is still walking the array. It then reads the offset and data window back to confirm that none of those writes landed, and it times the busy window to confirm that the stray command did not extend it. The second collision is the version check meeting the last byte of a load. The bench loads images whose version byte is 0, 1 and 0xFF, and it judges the defaults against its own model on every clock.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_SAVE, OP_ERASE} op_e;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_OFS  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef struct packed {
    logic        debug_en;
    logic        failsafe_off;
    logic        wdog_en;
    logic        bootmode_drive;
    logic        pwr_inhibit;
    logic [15:0] bootmode;
  } dflt_t;

  // exactly one command bit selects an operation; anything else is rejected
  function automatic op_e decode_cmd(input logic [2:0] bits);
    case (bits)
      3'b001:  return OP_LOAD;
      3'b010:  return OP_SAVE;
      3'b100:  return OP_ERASE;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic dflt_t decode_image(input logic [15:0] flags,
                                         input logic [15:0] bmode);
    dflt_t d;
    d.pwr_inhibit    = flags[0];
    d.bootmode_drive = flags[1];
    d.wdog_en        = flags[2];
    d.failsafe_off   = flags[3];
    d.debug_en       = flags[15];
    d.bootmode       = bmode;
    return d;
  endfunction

endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_store_pkg::*;
#(
  parameter int IMG_BYTES    = 8,
  parameter int CYC_PER_BYTE = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  op_e                          op_i,
  output logic                         busy,
  output op_e                          op_q,
  output logic [$clog2(IMG_BYTES)-1:0] idx,
  output logic                         xfer,
  output logic                         last
);
  localparam int IW = $clog2(IMG_BYTES);
  localparam int CW = $clog2(CYC_PER_BYTE);

  logic [CW-1:0] cyc;

  assign xfer = busy && (cyc == CW'(CYC_PER_BYTE - 1));
  assign last = (idx == IW'(IMG_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op_q <= OP_NONE;
      cyc  <= '0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        op_q <= op_i;
        cyc  <= '0;
        idx  <= '0;
      end
    end else if (xfer) begin
      cyc <= '0;
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_nv_array.sv
module cfg_nv_array
  import cfg_store_pkg::*;
#(
  parameter int IMG_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [$clog2(IMG_BYTES)-1:0] addr,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   rdata
);
  logic [IMG_BYTES-1:0][7:0] mem_q;

  assign rdata = mem_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < IMG_BYTES; i++) mem_q[i] <= ERASED_BYTE;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
#(
  parameter int IMG_BYTES    = 8,   // at least 5 for the version-0 layout
  parameter int CYC_PER_BYTE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        busy,
  output logic        dflt_pwr_inhibit,
  output logic        dflt_bootmode_drive,
  output logic        dflt_wdog_en,
  output logic        dflt_failsafe_off,
  output logic        dflt_debug_en,
  output logic [15:0] dflt_bootmode
);
  localparam int OFS_W = $clog2(IMG_BYTES);

  logic [IMG_BYTES-1:0][7:0] work_q;
  logic [IMG_BYTES-1:0][7:0] ld_img;
  logic [OFS_W-1:0]          ofs_q;
  dflt_t                     dflt_q;

  // named internal events
  op_e              cmd_op, seq_op;
  logic             start_ev, host_ofs_wr, host_data_wr;
  logic             xfer, last, load_step, load_done;
  logic [OFS_W-1:0] seq_idx;
  logic [7:0]       nv_rd, nv_wdata, ld_ver_byte;
  logic             nv_we;

  assign cmd_op       = decode_cmd(reg_wdata[2:0]);
  assign start_ev     = reg_wr && (reg_addr == REG_CMD) && !busy && (cmd_op != OP_NONE);
  assign host_ofs_wr  = reg_wr && (reg_addr == REG_OFS) && !busy;
  assign host_data_wr = reg_wr && (reg_addr == REG_DATA) && !busy;

  cfg_seq #(.IMG_BYTES(IMG_BYTES), .CYC_PER_BYTE(CYC_PER_BYTE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .op_i(cmd_op),
    .busy(busy), .op_q(seq_op), .idx(seq_idx), .xfer(xfer), .last(last)
  );

  assign nv_we    = xfer && ((seq_op == OP_SAVE) || (seq_op == OP_ERASE));
  assign nv_wdata = (seq_op == OP_ERASE) ? ERASED_BYTE : work_q[seq_idx];

  cfg_nv_array #(.IMG_BYTES(IMG_BYTES)) u_nv (
    .clk(clk), .rst_n(rst_n), .we(nv_we), .addr(seq_idx),
    .wdata(nv_wdata), .rdata(nv_rd)
  );

  assign load_step   = xfer && (seq_op == OP_LOAD);
  assign load_done   = load_step && last;
  assign ld_ver_byte = (seq_idx == '0) ? nv_rd : work_q[0];

  // image as it stands once the final byte lands; unknown layouts fall back
  always_comb begin
    ld_img          = work_q;
    ld_img[seq_idx] = nv_rd;
    if (ld_ver_byte != 8'h00) ld_img = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q <= '0;
      ofs_q  <= '0;
    end else begin
      if (load_done)         work_q          <= ld_img;
      else if (load_step)    work_q[seq_idx] <= nv_rd;
      else if (host_data_wr) work_q[ofs_q]   <= reg_wdata;
      if (host_ofs_wr) ofs_q <= reg_wdata[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         dflt_q <= '0;
    else if (load_done) dflt_q <= decode_image({ld_img[2], ld_img[1]},
                                               {ld_img[4], ld_img[3]});
  end

  always_comb begin
    case (reg_addr)
      REG_CMD:  reg_rdata = {busy, 7'b0};
      REG_OFS:  reg_rdata = 8'(ofs_q);
      REG_DATA: reg_rdata = work_q[ofs_q];
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign dflt_pwr_inhibit    = dflt_q.pwr_inhibit;
  assign dflt_bootmode_drive = dflt_q.bootmode_drive;
  assign dflt_wdog_en        = dflt_q.wdog_en;
  assign dflt_failsafe_off   = dflt_q.failsafe_off;
  assign dflt_debug_en       = dflt_q.debug_en;
  assign dflt_bootmode       = dflt_q.bootmode;
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        busy,
  input logic        start_ev,
  input logic        xfer,
  input logic        last,
  input logic        load_done,
  input logic [7:0]  ld_ver_byte,
  input logic        dflt_debug_en,
  input logic        dflt_pwr_inhibit,
  input logic [15:0] dflt_bootmode
);
  logic multi_cmd;
  assign multi_cmd = reg_wr && (reg_addr == 2'd0) && !busy &&
                     ($countones(reg_wdata[2:0]) > 1);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy); // R4

  AST_MULTI_CMD_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    multi_cmd |=> !busy); // R5

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(xfer && last)) |=> busy); // R6

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last) |=> !busy); // R6

  AST_BAD_VERSION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && ld_ver_byte != 8'h00) |=>
      (dflt_bootmode == 16'h0 && !dflt_debug_en && !dflt_pwr_inhibit)); // R9

  AST_DFLT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |=> ($stable(dflt_bootmode) && $stable(dflt_debug_en))); // R11
endmodule

bind cfg_store_ctrl cfg_store_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .start_ev(start_ev), .xfer(xfer),
  .last(last), .load_done(load_done), .ld_ver_byte(ld_ver_byte),
  .dflt_debug_en(dflt_debug_en), .dflt_pwr_inhibit(dflt_pwr_inhibit),
  .dflt_bootmode(dflt_bootmode)
);

// File: tb/cfg_store_ctrl_bench.sv
module cfg_store_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 8;
  localparam int CPB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        busy;
  logic        d_pi, d_bd, d_we, d_fo, d_de;
  logic [15:0] d_bm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cfg_store_ctrl #(.IMG_BYTES(NB), .CYC_PER_BYTE(CPB)) u_cfg_store_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .dflt_pwr_inhibit(d_pi), .dflt_bootmode_drive(d_bd), .dflt_wdog_en(d_we),
    .dflt_failsafe_off(d_fo), .dflt_debug_en(d_de), .dflt_bootmode(d_bm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int   m_busy, m_cyc, m_idx, m_op, m_ofs;
  byte  unsigned m_work[NB];
  byte  unsigned m_nv[NB];
  logic [15:0] m_flags, m_boot;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cyc = 0; m_idx = 0; m_op = 0; m_ofs = 0;
      m_flags = '0; m_boot = '0;
      for (int i = 0; i < NB; i++) begin m_work[i] = 8'h00; m_nv[i] = 8'hFF; end
    end else if (m_busy != 0) begin
      m_cyc++;
      if (m_cyc == CPB) begin
        m_cyc = 0;
        if (m_op == 1)      m_work[m_idx] = m_nv[m_idx];
        else if (m_op == 2) m_nv[m_idx] = m_work[m_idx];
        else                m_nv[m_idx] = 8'hFF;
        if (m_idx == NB - 1) begin
          m_busy = 0;
          if (m_op == 1) begin
            if (m_work[0] != 0) for (int i = 0; i < NB; i++) m_work[i] = 8'h00;
            m_flags = {m_work[2], m_work[1]};
            m_boot  = {m_work[4], m_work[3]};
          end
        end else m_idx++;
      end
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: if (reg_wdata[2:0] == 3'b001 || reg_wdata[2:0] == 3'b010 ||
                  reg_wdata[2:0] == 3'b100) begin
                m_busy = 1; m_cyc = 0; m_idx = 0;
                m_op = reg_wdata[0] ? 1 : (reg_wdata[1] ? 2 : 3);
              end
        2'd1: m_ofs = int'(reg_wdata[2:0]);
        2'd2: m_work[m_ofs] = reg_wdata;
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // every clock: registered outputs against the model (R6, R8, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(busy == (m_busy != 0), "R6", "busy", int'(busy), m_busy);
      check({d_de, d_fo, d_we, d_bd, d_pi} ==
            {m_flags[15], m_flags[3], m_flags[2], m_flags[1], m_flags[0]},
            "R11", "default flags", int'({d_de, d_fo, d_we, d_bd, d_pi}),
            int'({m_flags[15], m_flags[3:0]}));
      check(d_bm == m_boot, "R8", "default bootmode", int'(d_bm), int'(m_boot));
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, "register read", int'(reg_rdata), int'(exp));
  endtask

  // issue a command and time the busy window
  task automatic run_cmd(input logic [7:0] c, input string req);
    int n = 0;
    wr_reg(2'd0, c);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(n == NB * CPB, req, "busy length", n, NB * CPB);
  endtask

  task automatic put_image(input logic [7:0] img [NB]);
    for (int i = 0; i < NB; i++) begin
      wr_reg(2'd1, 8'(i));
      wr_reg(2'd2, img[i]);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin @(posedge clk); wd++; end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] img [NB];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 8'h00, "R1");
    rd(2'd1, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1");
    check(busy == 0 && d_bm == 0 && d_de == 0, "R1", "reset outputs",
          int'({busy, d_de}), 0);

    // R2 window access, offset keeps bits 2:0
    img = '{8'h00, 8'h05, 8'h80, 8'h34, 8'h12, 8'hAA, 8'h55, 8'h0F};
    put_image(img);
    wr_reg(2'd1, 8'hFB);
    rd(2'd1, 8'h03, "R2");
    rd(2'd2, 8'h34, "R2");

    // R3 R7 save, then spoil the working copy; R11 defaults untouched
    run_cmd(8'h02, "R6");
    wr_reg(2'd1, 8'd1);
    wr_reg(2'd2, 8'h00);
    check(d_de == 0 && d_bm == 0, "R11", "defaults before load", int'(d_bm), 0);

    // R3 R8 load restores and decodes
    run_cmd(8'h01, "R6");
    rd(2'd2, 8'h05, "R7");
    check(d_pi == 1 && d_bd == 0 && d_we == 1 && d_fo == 0 && d_de == 1, "R8",
          "flag decode", int'({d_de, d_fo, d_we, d_bd, d_pi}), 'h15);
    check(d_bm == 16'h1234, "R8", "bootmode decode", int'(d_bm), 'h1234);

    // R5 multi-bit commands rejected
    wr_reg(2'd0, 8'h03);
    check(busy == 0, "R5", "busy after 0x03", int'(busy), 0);
    wr_reg(2'd0, 8'h06);
    rd(2'd0, 8'h00, "R5");

    // R4 R10 collision: host writes during an erase
    wr_reg(2'd0, 8'h04);
    rd(2'd0, 8'h80, "R4");
    wr_reg(2'd2, 8'h77);
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd0, 8'h01);
    begin
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
    end
    rd(2'd1, 8'h01, "R10");
    rd(2'd2, 8'h05, "R10");

    // R7 R9 load after erase: version 0xFF falls back to zero
    run_cmd(8'h01, "R6");
    rd(2'd2, 8'h00, "R9");
    check(d_bm == 0 && d_de == 0 && d_pi == 0, "R9", "defaults after erased load",
          int'(d_bm), 0);

    // R9 version 1 image with non-zero fields
    img = '{8'h01, 8'h0F, 8'h80, 8'hCD, 8'hAB, 8'h00, 8'h00, 8'h00};
    put_image(img);
    run_cmd(8'h02, "R7");
    run_cmd(8'h01, "R9");
    wr_reg(2'd1, 8'd3);
    rd(2'd2, 8'h00, "R9");
    check(d_bm == 0 && d_we == 0, "R9", "version 1 defaults", int'(d_bm), 0);

    // R8 second version-0 pattern
    img = '{8'h00, 8'h0A, 8'h00, 8'hEF, 8'hBE, 8'h11, 8'h22, 8'h33};
    put_image(img);
    run_cmd(8'h02, "R7");
    run_cmd(8'h01, "R8");
    check(d_bd == 1 && d_fo == 1 && d_pi == 0 && d_de == 0, "R8", "flag decode 2",
          int'({d_de, d_fo, d_we, d_bd, d_pi}), 'h0A);
    check(d_bm == 16'hBEEF, "R8", "bootmode decode 2", int'(d_bm), 'hBEEF);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule